// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device out of power-up. After reset it drives a fixed list of steps onto a single-phase command bus. It first turns on the clock-enable, on-die-termination and device-reset pins. It then precharges all banks, issues auto-refreshes and loads the mode registers. When the list is finished it raises a done flag, and from then on it leaves the bus idle so that a normal memory controller can take over.

The memory family is chosen by a parameter: SDR, DDR, LPDDR or DDR2. The mode-register word is derived in hardware from the CAS latency and the PHY phase count. The step list differs by family. DDR2 adds two extended-mode writes that enter and then leave off-chip-driver calibration. Every command lasts one clock. It is followed by a wait of a parameterised number of idle cycles, and the wait after the last main mode load is 200 cycles by default. Elaboration stops with an error for DDR3 or any other unsupported family, for a non-power-of-two phase count, and for an address bus narrower than 11 bits.

Top module: `sdram_init_seq`

## Requirements
- R1: While rstN is low: done=0, cke=0, odt=0, resetN=0, csN=0, {rasN,casN,weN}=3'b111 (NOP), addr=0 and bank=0.
- R2: Command codes on {rasN,casN,weN}: NOP 3'b111, precharge 3'b010, auto-refresh 3'b001, mode-register load 3'b000. csN is held low.
- R3: Step order for SDR: clock-enable, precharge, refresh, refresh, main mode load. Step order for DDR, LPDDR and DDR2: clock-enable, precharge, extended-mode load, main mode load with DLL reset, precharge, refresh, refresh, main mode load. DDR2 then adds an OCD-default extended load and an OCD-exit extended load.
- R4: The main mode word is log2(BL) + (CAS_LAT << 4). BL is NUM_PHASES for SDR and 2*NUM_PHASES otherwise. DDR2 also adds 2 << 9 (write recovery).
- R5: The DLL-reset mode word is the main word with bit 8 set. A precharge drives addr = 1 << 10 (A10 high, all banks). Refresh drives addr = 0.
- R6: Extended-mode loads use bank = 1. Main mode loads and all other steps use bank = 0.
- R7: On DDR2, the OCD-default load carries addr bits [9:7] = 3'b111 and all other bits 0. The following OCD-exit load carries addr = 0.
- R8: Each step lasts exactly one cycle and is followed by exactly its wait count of NOP cycles. The counts are W_CKE, W_PRE, W_REF, W_MRS for extended and DLL-reset loads, and W_FINAL after the last main mode load. A count of 0 puts the next step in the very next cycle.
- R9: cke, odt and resetN rise together in the cycle of the clock-enable step, which is itself a NOP. They stay high until reset, and no non-NOP command occurs before that step.
- R10: done rises in the cycle after the last wait cycle of the last step, or right after the last step if its wait is 0. It stays high until reset, and the bus shows NOP while it is high.
- R11: Asserting rstN at any point of the sequence returns the block to the R1 state. After release the sequence restarts from its first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address / mode word |
| bank | output | BANK_W | Bank address |
| cke | output | 1 | Clock enable |
| odt | output | 1 | On-die termination |
| resetN | output | 1 | Device reset, active low |
| done | output | 1 | Sequence complete |

## Verification
Two things can happen in the same cycle: the wait counter of one step expiring and the next command issuing. When a wait of 0 is configured, that next command falls in the cycle right after the previous one. The bench builds a DDR2 instance whose extended-mode waits are 0, so the DLL-reset load follows the extended load back to back, and the two OCD loads end the sequence with done rising in the very next cycle. Every step is checked against the cycle the bench predicts from the cumulative wait counts. Random mid-sequence resets check that no partial count survives.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  typedef enum logic [2:0] {
    FAM_SDR   = 3'd0,
    FAM_DDR   = 3'd1,
    FAM_LPDDR = 3'd2,
    FAM_DDR2  = 3'd3,
    FAM_DDR3  = 3'd4
  } memFamily_e;

  typedef enum logic [2:0] {
    K_CKE, K_PRE, K_REF, K_EMR, K_MRDLL, K_MR, K_OCD, K_OCDX
  } stepKind_e;

  typedef struct packed {
    logic issue;
    logic loadWait;
    logic countDown;
  } seqStrobe_t;

  function automatic int stepCount(memFamily_e fam);
    if (fam == FAM_SDR) return 5;
    if (fam == FAM_DDR2) return 10;
    return 8;
  endfunction

  function automatic stepKind_e kindAt(memFamily_e fam, int idx);
    if (fam == FAM_SDR) begin
      case (idx)
        0: return K_CKE;
        1: return K_PRE;
        2, 3: return K_REF;
        default: return K_MR;
      endcase
    end
    case (idx)
      0: return K_CKE;
      1, 4: return K_PRE;
      2: return K_EMR;
      3: return K_MRDLL;
      5, 6: return K_REF;
      7: return K_MR;
      8: return K_OCD;
      default: return K_OCDX;
    endcase
  endfunction

endpackage

// File: rtl/sdinit_datapath.sv
module sdinit_datapath
  import sdinit_pkg::*;
#(
  parameter memFamily_e MEM_FAMILY = FAM_DDR2,
  parameter int NUM_PHASES = 2,
  parameter int CAS_LAT    = 3,
  parameter int ADDR_W     = 13,
  parameter int BANK_W     = 2,
  parameter int W_CKE      = 4,
  parameter int W_PRE      = 2,
  parameter int W_REF      = 8,
  parameter int W_MRS      = 2,
  parameter int W_FINAL    = 200,
  parameter int STEP_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [STEP_W-1:0] stepIdx,
  output logic              waitIsZero,
  output logic              cntZero,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic              cke
);

  localparam int BURST   = (MEM_FAMILY == FAM_SDR) ? NUM_PHASES : 2 * NUM_PHASES;
  localparam int WR_ADD  = (MEM_FAMILY == FAM_DDR2) ? (2 << 9) : 0;
  localparam int MR_BASE = $clog2(BURST) + (CAS_LAT << 4) + WR_ADD;
  localparam logic [ADDR_W-1:0] MR_WORD  = ADDR_W'(MR_BASE);
  localparam logic [ADDR_W-1:0] DLL_WORD = MR_WORD | ADDR_W'(1 << 8);
  localparam logic [ADDR_W-1:0] OCD_WORD = ADDR_W'(7 << 7);
  localparam logic [ADDR_W-1:0] A10_WORD = ADDR_W'(1 << 10);
  localparam int MAX_A    = (W_CKE > W_PRE) ? W_CKE : W_PRE;
  localparam int MAX_B    = (W_REF > W_MRS) ? W_REF : W_MRS;
  localparam int MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_WAIT = (MAX_C > W_FINAL) ? MAX_C : W_FINAL;
  localparam int CNT_W    = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT + 1);

  stepKind_e        curKind;
  logic [CNT_W-1:0] curWait;
  logic [CNT_W-1:0] cnt;
  logic             ckeOn;

  always_comb begin
    curKind = kindAt(MEM_FAMILY, int'(stepIdx));
    case (curKind)
      K_CKE:   curWait = CNT_W'(W_CKE);
      K_PRE:   curWait = CNT_W'(W_PRE);
      K_REF:   curWait = CNT_W'(W_REF);
      K_MR:    curWait = CNT_W'(W_FINAL);
      default: curWait = CNT_W'(W_MRS);
    endcase
  end

  assign waitIsZero = (curWait == '0);
  assign cntZero    = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cnt <= '0;
    else if (strobe.loadWait)  cnt <= curWait - 1'b1;
    else if (strobe.countDown) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    ckeOn <= 1'b0;
    else if (strobe.issue && curKind == K_CKE)    ckeOn <= 1'b1;
  end

  assign cke = ckeOn | (strobe.issue && curKind == K_CKE);

  always_comb begin
    {rasN, casN, weN} = 3'b111;
    addr = '0;
    bank = '0;
    if (strobe.issue) begin
      case (curKind)
        K_PRE:   begin {rasN, casN, weN} = 3'b010; addr = A10_WORD; end
        K_REF:   {rasN, casN, weN} = 3'b001;
        K_EMR:   begin {rasN, casN, weN} = 3'b000; bank = BANK_W'(1); end
        K_MRDLL: begin {rasN, casN, weN} = 3'b000; addr = DLL_WORD; end
        K_MR:    begin {rasN, casN, weN} = 3'b000; addr = MR_WORD; end
        K_OCD:   begin {rasN, casN, weN} = 3'b000; addr = OCD_WORD; bank = BANK_W'(1); end
        K_OCDX:  begin {rasN, casN, weN} = 3'b000; bank = BANK_W'(1); end
        default: {rasN, casN, weN} = 3'b111;
      endcase
    end
  end

endmodule

// File: rtl/sdinit_control.sv
module sdinit_control
  import sdinit_pkg::*;
#(
  parameter int NUM_STEPS = 10,
  parameter int STEP_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              waitIsZero,
  input  logic              cntZero,
  output seqStrobe_t        strobe,
  output logic [STEP_W-1:0] stepIdx,
  output logic              done
);

  typedef enum logic [1:0] {S_START, S_ISSUE, S_WAIT, S_DONE} ctlState_e;

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  ctlState_e state;
  logic      advance;

  always_comb begin
    strobe.issue     = (state == S_ISSUE);
    strobe.loadWait  = (state == S_ISSUE) && !waitIsZero;
    strobe.countDown = (state == S_WAIT) && !cntZero;
    advance = ((state == S_ISSUE) && waitIsZero) || ((state == S_WAIT) && cntZero);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_START;
      stepIdx <= '0;
    end else begin
      case (state)
        S_START: state <= S_ISSUE;
        S_ISSUE: if (!waitIsZero) state <= S_WAIT;
        default: ;
      endcase
      if (advance) begin
        if (stepIdx == LAST_STEP) begin
          state <= S_DONE;
        end else begin
          stepIdx <= stepIdx + 1'b1;
          state   <= S_ISSUE;
        end
      end
    end
  end

  assign done = (state == S_DONE);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdinit_pkg::*;
#(
  parameter memFamily_e MEM_FAMILY = FAM_DDR2,
  parameter int NUM_PHASES = 2,
  parameter int CAS_LAT    = 3,
  parameter int ADDR_W     = 13,
  parameter int BANK_W     = 2,
  parameter int W_CKE      = 4,
  parameter int W_PRE      = 2,
  parameter int W_REF      = 8,
  parameter int W_MRS      = 2,
  parameter int W_FINAL    = 200
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic              cke,
  output logic              odt,
  output logic              resetN,
  output logic              done
);

  localparam int NUM_STEPS = stepCount(MEM_FAMILY);
  localparam int STEP_W    = $clog2(NUM_STEPS);

  if (MEM_FAMILY == FAM_DDR3 || MEM_FAMILY > FAM_DDR3) begin : famReject
    $error("sdram_init_seq: memory family not supported");
  end
  if (NUM_PHASES < 1 || (NUM_PHASES & (NUM_PHASES - 1)) != 0) begin : phaseReject
    $error("sdram_init_seq: phase count must be a power of two");
  end
  if (ADDR_W < 11 || BANK_W < 1) begin : widthReject
    $error("sdram_init_seq: address or bank bus too narrow");
  end

  seqStrobe_t        strobe;
  logic [STEP_W-1:0] stepIdx;
  logic              waitIsZero;
  logic              cntZero;
  logic              ckeInt;

  sdinit_control #(.NUM_STEPS(NUM_STEPS), .STEP_W(STEP_W)) uCtl (
    .clk(clk), .rstN(rstN), .waitIsZero(waitIsZero), .cntZero(cntZero),
    .strobe(strobe), .stepIdx(stepIdx), .done(done)
  );

  sdinit_datapath #(
    .MEM_FAMILY(MEM_FAMILY), .NUM_PHASES(NUM_PHASES), .CAS_LAT(CAS_LAT),
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .W_CKE(W_CKE), .W_PRE(W_PRE),
    .W_REF(W_REF), .W_MRS(W_MRS), .W_FINAL(W_FINAL), .STEP_W(STEP_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stepIdx(stepIdx),
    .waitIsZero(waitIsZero), .cntZero(cntZero),
    .rasN(rasN), .casN(casN), .weN(weN), .addr(addr), .bank(bank), .cke(ckeInt)
  );

  assign csN    = 1'b0;
  assign cke    = ckeInt;
  assign odt    = ckeInt;
  assign resetN = ckeInt;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] bank,
  input logic              cke,
  input logic              done
);

  logic isNop, isPre, isMode;
  assign isNop  = ({rasN, casN, weN} == 3'b111);
  assign isPre  = ({rasN, casN, weN} == 3'b010);
  assign isMode = ({rasN, casN, weN} == 3'b000);

  // R9
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rstN) cke |=> cke);

  // R9
  no_cmd_before_cke_chk: assert property (@(posedge clk) disable iff (!rstN) !cke |-> isNop);

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> done);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> (isNop && cke));

  // R5
  pre_a10_chk: assert property (@(posedge clk) disable iff (!rstN) isPre |-> addr[10]);

  // R6
  mode_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isMode && bank != '0) |-> (bank == BANK_W'(1)));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) chk (
  .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN),
  .addr(addr), .bank(bank), .cke(cke), .done(done)
);

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;
  import sdinit_pkg::*;

  localparam int NI = 3;
  localparam memFamily_e FAM[NI] = '{FAM_DDR2, FAM_SDR, FAM_DDR};
  localparam int PH[NI]  = '{2, 4, 1};
  localparam int CL[NI]  = '{3, 2, 2};
  localparam int WCK[NI] = '{3, 2, 1};
  localparam int WPR[NI] = '{1, 3, 2};
  localparam int WRF[NI] = '{4, 5, 3};
  localparam int WMR[NI] = '{0, 2, 2};
  localparam int WFN = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]  cmdOf [NI];
  logic [12:0] addrOf[NI];
  logic [1:0]  bankOf[NI];
  logic        csOf[NI], ckeOf[NI], odtOf[NI], rstOf[NI], doneOf[NI];

  for (genvar g = 0; g < NI; g++) begin : gDut
    logic rN, cN, wN;
    if (g == 0) begin : gI
      sdram_init_seq #(.MEM_FAMILY(FAM[0]), .NUM_PHASES(PH[0]), .CAS_LAT(CL[0]),
        .W_CKE(WCK[0]), .W_PRE(WPR[0]), .W_REF(WRF[0]), .W_MRS(WMR[0]), .W_FINAL(WFN)) u0 (
        .clk(clk), .rstN(rstN), .csN(csOf[g]), .rasN(rN), .casN(cN), .weN(wN),
        .addr(addrOf[g]), .bank(bankOf[g]), .cke(ckeOf[g]), .odt(odtOf[g]),
        .resetN(rstOf[g]), .done(doneOf[g]));
    end else begin : gI
      sdram_init_seq #(.MEM_FAMILY(FAM[g]), .NUM_PHASES(PH[g]), .CAS_LAT(CL[g]),
        .W_CKE(WCK[g]), .W_PRE(WPR[g]), .W_REF(WRF[g]), .W_MRS(WMR[g]), .W_FINAL(WFN)) u1 (
        .clk(clk), .rstN(rstN), .csN(csOf[g]), .rasN(rN), .casN(cN), .weN(wN),
        .addr(addrOf[g]), .bank(bankOf[g]), .cke(ckeOf[g]), .odt(odtOf[g]),
        .resetN(rstOf[g]), .done(doneOf[g]));
    end
    assign cmdOf[g] = {rN, cN, wN};
  end

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench model of the step list (R3)
  function automatic int nSteps(int i);
    return (FAM[i] == FAM_SDR) ? 5 : (FAM[i] == FAM_DDR2) ? 10 : 8;
  endfunction
  function automatic int kindOf(int i, int k); // 0 cke 1 pre 2 ref 3 emr 4 dll 5 mr 6 ocd 7 exit
    if (FAM[i] == FAM_SDR) return (k == 0) ? 0 : (k == 1) ? 1 : (k < 4) ? 2 : 5;
    case (k)
      0: return 0;
      1, 4: return 1;
      2: return 3;
      3: return 4;
      5, 6: return 2;
      7: return 5;
      8: return 6;
      default: return 7;
    endcase
  endfunction
  function automatic int mrWord(int i); // R4
    int bl = (FAM[i] == FAM_SDR) ? PH[i] : 2 * PH[i];
    return $clog2(bl) + (CL[i] << 4) + ((FAM[i] == FAM_DDR2) ? 1024 : 0);
  endfunction
  function automatic int expCmd(int kd);
    return (kd == 0) ? 7 : (kd == 1) ? 2 : (kd == 2) ? 1 : 0;
  endfunction
  function automatic int expAddr(int i, int kd);
    case (kd)
      1: return 1024;
      4: return mrWord(i) | 256;
      5: return mrWord(i);
      6: return 896;
      default: return 0;
    endcase
  endfunction
  function automatic int expBank(int kd);
    return (kd == 3 || kd == 6 || kd == 7) ? 1 : 0;
  endfunction
  function automatic int expWait(int i, int kd);
    case (kd)
      0: return WCK[i];
      1: return WPR[i];
      2: return WRF[i];
      5: return WFN;
      default: return WMR[i];
    endcase
  endfunction

  int cyc = 0;
  always @(posedge clk) cyc <= rstN ? cyc + 1 : 0;

  int expStep[NI], nextCyc[NI], gapErr[NI];

  always @(negedge clk) begin
    for (int i = 0; i < NI; i++) begin
      if (!rstN) begin
        expStep[i] = 0; nextCyc[i] = -1;
      end else begin
        bool_step(i);
      end
    end
  end

  task automatic bool_step(input int i);
    int kd;
    if (expStep[i] < nSteps(i)) begin
      if ((nextCyc[i] < 0 && ckeOf[i]) || (nextCyc[i] >= 0 && cyc == nextCyc[i])) begin
        kd = kindOf(i, expStep[i]);
        check(cmdOf[i] == 3'(expCmd(kd)), "R2/R3 command code", cmdOf[i], expCmd(kd));
        if (kd == 4 || kd == 5)
          check(addrOf[i] == 13'(expAddr(i, kd)), "R4/R5 mode word", addrOf[i], expAddr(i, kd));
        else if (kd >= 6)
          check(addrOf[i] == 13'(expAddr(i, kd)), "R7 OCD word", addrOf[i], expAddr(i, kd));
        else
          check(addrOf[i] == 13'(expAddr(i, kd)), "R5 address", addrOf[i], expAddr(i, kd));
        check(bankOf[i] == 2'(expBank(kd)), "R6 bank", bankOf[i], expBank(kd));
        check(ckeOf[i] && odtOf[i] && rstOf[i] && !csOf[i], "R9 pins high",
              {ckeOf[i], odtOf[i], rstOf[i]}, 7);
        nextCyc[i] = cyc + 1 + expWait(i, kd);
        expStep[i]++;
      end else if (cmdOf[i] != 3'b111 || doneOf[i] || (nextCyc[i] >= 0 && !ckeOf[i])) begin
        gapErr[i]++; // R8: only NOPs between steps
        $display("FAIL R8 inst%0d unexpected activity at cycle %0d actual=%0d expected=7",
                 i, cyc, cmdOf[i]);
      end
    end else if (cyc == nextCyc[i]) begin
      check(doneOf[i] == 1'b1, "R10 done rises", doneOf[i], 1);
      nextCyc[i] = -2;
    end else if (nextCyc[i] == -2) begin
      if (!doneOf[i] || cmdOf[i] != 3'b111) begin
        gapErr[i]++;
        $display("FAIL R10 inst%0d done dropped or bus busy actual=%0d expected=1", i, doneOf[i]);
      end
    end else if (doneOf[i] || cmdOf[i] != 3'b111) begin
      gapErr[i]++;
      $display("FAIL R8 inst%0d early done or command in final wait actual=%0d expected=0",
               i, doneOf[i]);
    end
  endtask

  task automatic checkReset(input string req);
    for (int i = 0; i < NI; i++) begin
      check(!doneOf[i] && !ckeOf[i] && !odtOf[i] && !rstOf[i], {req, " control pins low"},
            {doneOf[i], ckeOf[i], odtOf[i], rstOf[i]}, 0);
      check(cmdOf[i] == 3'b111 && !csOf[i] && addrOf[i] == 0 && bankOf[i] == 0,
            {req, " idle bus"}, cmdOf[i], 7);
    end
  endtask

  initial begin
    for (int i = 0; i < NI; i++) gapErr[i] = 0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    checkReset("R1");
    // random mid-sequence resets
    for (int r = 0; r < 4; r++) begin
      int len = (r == 0) ? 1 : int'($urandom_range(5, 260));
      @(negedge clk) rstN = 1'b1;
      repeat (len) @(negedge clk);
      rstN = 1'b0;
      #1;
      checkReset("R11");
      repeat (2) @(negedge clk);
    end
    @(negedge clk) rstN = 1'b1;
    repeat (320) @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      check(expStep[i] == nSteps(i), "R3 all steps seen", expStep[i], nSteps(i));
      check(nextCyc[i] == -2 && doneOf[i], "R10 done held", doneOf[i], 1);
      check(gapErr[i] == 0, "R8 wait spacing", gapErr[i], 0);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule